// File: doc/BRIEF.md
# Multi-Mode Transmit Payload Input Port

This block is the input stage of one transmit channel. Eight shared data pins carry payload from the local terminal equipment, and a static channel mode decides what those pins mean. In nibble framer mode the low four pins carry nibbles. The block produces a nibble clock and samples each nibble as that clock falls. It packs two nibbles into one byte. In HDLC mode all eight pins form a byte. The block produces a byte clock and samples each byte as that clock rises. In serial framer mode and in ATM mode the pins belong to other logic, so this block ignores them.

Both pin clocks are derived from the system clock with a programmable half-period. Because the block drives them, it sets the pace of the external equipment. Captured bytes leave on an internal byte stream with a one-cycle valid strobe. A change of mode drops any half-built byte and holds the pin clocks low for one full period before they restart.

Top module: `tx_payload_port`

## Requirements
- R1: `mode_i` uses these encodings: 0 selects serial framer, 1 selects nibble framer, 2 selects HDLC and 3 selects ATM.
- R2: In a steady mode, the active pin clock stays high for `div_half_i`+1 system cycles and then low for `div_half_i`+1 cycles. `nib_clk_o` toggles only in nibble mode and `byte_clk_o` toggles only in HDLC mode. Each pin clock is low in every other mode and out of reset.
- R3: In nibble mode, `data_i[3:0]` is sampled at the system edge where `nib_clk_o` falls, with `data_i[0]` as the LSB. `data_i[7:4]` has no effect.
- R4: In nibble mode, the first nibble captured after a mode entry goes to `byte_o[7:4]` and the next one goes to `byte_o[3:0]`. `byte_vld_o` is high for exactly one cycle, beginning at the same edge where `nib_clk_o` falls for the second nibble.
- R5: In HDLC mode, `data_i[7:0]` is sampled at the system edge where `byte_clk_o` rises. `byte_o` then presents that byte, and `byte_vld_o` is high for one cycle beginning at that same edge.
- R6: In serial framer mode, `byte_vld_o` stays low and both pin clocks stay low, whatever `data_i` carries.
- R7: In ATM mode, `byte_vld_o` stays low and both pin clocks stay low, whatever `data_i` carries.
- R8: A mode change is seen at the first system edge after `mode_i` changes. That edge discards any stored first nibble and captures nothing. The new mode's pin clock then stays low for 2*(`div_half_i`+1) cycles and rises at the edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Channel mode (R1 encoding) |
| div_half_i | input | DIV_W | Pin clock half-period minus one, in system cycles |
| data_i | input | BYTE_W | Shared payload pins |
| nib_clk_o | output | 1 | Nibble clock to the terminal equipment |
| byte_clk_o | output | 1 | Byte clock to the terminal equipment |
| byte_o | output | BYTE_W | Assembled or captured byte |
| byte_vld_o | output | 1 | One-cycle strobe marking `byte_o` valid |

## Verification
A mode change and a capture edge can land on the same system cycle, and the mode change must win. To provoke this, the bench stores a first nibble. It presents a second nibble and switches the mode at exactly the edge where `nib_clk_o` would have fallen. It then judges that no byte is strobed there. After it returns to nibble mode, the next byte must hold only fresh nibbles. A second run changes the mode after a lone third nibble and checks that this nibble never reaches a byte.

// File: rtl/tx_port_pkg.sv
package tx_port_pkg;
  typedef enum logic [1:0] {
    MODE_SERIAL = 2'd0,
    MODE_NIBBLE = 2'd1,
    MODE_HDLC   = 2'd2,
    MODE_ATM    = 2'd3
  } port_mode_e;
endpackage

// File: rtl/tx_pclk_gen.sv
module tx_pclk_gen
  import tx_port_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  port_mode_e       mode_i,
  input  logic [DIV_W-1:0] div_half_i,
  output port_mode_e       mode_o,
  output logic             mode_chg_o,
  output logic             pclk_o,
  output logic             fall_o,
  output logic             rise_o
);
  port_mode_e       mode_q;
  logic [DIV_W-1:0] cnt_q;
  logic             pclk_q, hold_q, hold_ph_q;
  logic             term;

  assign mode_chg_o = (mode_i != mode_q);
  assign term       = (cnt_q >= div_half_i);
  assign fall_o     = term & ~mode_chg_o & ~hold_q & pclk_q;
  // rising edge: normal toggle, or end of the post-change low hold
  assign rise_o     = term & ~mode_chg_o &
                      ((~hold_q & ~pclk_q) | (hold_q & hold_ph_q));
  assign mode_o     = mode_q;
  assign pclk_o     = pclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_SERIAL;
      cnt_q     <= '0;
      pclk_q    <= 1'b0;
      hold_q    <= 1'b1;
      hold_ph_q <= 1'b0;
    end else if (mode_chg_o) begin
      mode_q    <= mode_i;
      cnt_q     <= '0;
      pclk_q    <= 1'b0;
      hold_q    <= 1'b1;
      hold_ph_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      if (hold_q) begin
        if (hold_ph_q) begin
          hold_q <= 1'b0;
          pclk_q <= 1'b1;
        end else begin
          hold_ph_q <= 1'b1;
        end
      end else begin
        pclk_q <= ~pclk_q;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_pclk_steady_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!term && !mode_chg_o) |=> $stable(pclk_q));

  p_hold_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |=> (!pclk_q && !rise_o && !fall_o));
endmodule

// File: rtl/tx_byte_assemble.sv
module tx_byte_assemble
  import tx_port_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NIB_W = BYTE_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  port_mode_e        mode_i,
  input  logic              mode_chg_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o
);
  logic [NIB_W-1:0]  hi_q;
  logic              have_hi_q;
  logic [BYTE_W-1:0] byte_q;
  logic              vld_q;
  logic              nib_cap, byte_cap;

  assign nib_cap  = fall_i & (mode_i == MODE_NIBBLE);
  assign byte_cap = rise_i & (mode_i == MODE_HDLC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q      <= '0;
      have_hi_q <= 1'b0;
      byte_q    <= '0;
      vld_q     <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (mode_chg_i) begin
        have_hi_q <= 1'b0;
      end else if (nib_cap) begin
        if (have_hi_q) begin
          byte_q    <= {hi_q, data_i[NIB_W-1:0]};
          vld_q     <= 1'b1;
          have_hi_q <= 1'b0;
        end else begin
          hi_q      <= data_i[NIB_W-1:0];
          have_hi_q <= 1'b1;
        end
      end else if (byte_cap) begin
        byte_q <= data_i;
        vld_q  <= 1'b1;
      end
    end
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;

  p_vld_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);

  p_vld_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (mode_i == MODE_NIBBLE || mode_i == MODE_HDLC));

  p_partial_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_i |=> (!have_hi_q && !vld_q));
endmodule

// File: rtl/tx_payload_port.sv
module tx_payload_port
  import tx_port_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [DIV_W-1:0]  div_half_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              nib_clk_o,
  output logic              byte_clk_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o
);
  port_mode_e mode_q;
  logic       mode_chg, pclk, fall, rise;

  tx_pclk_gen #(.DIV_W(DIV_W)) u_pclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (port_mode_e'(mode_i)),
    .div_half_i (div_half_i),
    .mode_o     (mode_q),
    .mode_chg_o (mode_chg),
    .pclk_o     (pclk),
    .fall_o     (fall),
    .rise_o     (rise)
  );

  tx_byte_assemble #(.BYTE_W(BYTE_W)) u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .mode_chg_i (mode_chg),
    .fall_i     (fall),
    .rise_i     (rise),
    .data_i     (data_i),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o)
  );

  assign nib_clk_o  = pclk & (mode_q == MODE_NIBBLE);
  assign byte_clk_o = pclk & (mode_q == MODE_HDLC);

  p_clk_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nib_clk_o && byte_clk_o));
endmodule

// File: tb/tx_payload_port_test.sv
module tx_payload_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] div = 8'd2;
  logic [7:0] data = 8'h00;
  logic       nib_clk, byte_clk, vld;
  logic [7:0] byte_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [7:0] rx [256];
  int rx_n = 0;
  logic prev_n = 1'b0, prev_b = 1'b0;
  int clk_hi_seen = 0;

  always #4 clk = ~clk;

  tx_payload_port uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .div_half_i(div),
    .data_i(data), .nib_clk_o(nib_clk), .byte_clk_o(byte_clk),
    .byte_o(byte_out), .byte_vld_o(vld)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pack(input logic [3:0] a, input logic [3:0] b);
    return {a, b};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // monitor, sampled 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if ((nib_clk && mode != 2'd1) || (byte_clk && mode != 2'd2))
        clk_hi_seen++;
      if (vld) begin
        rx[rx_n[7:0]] = byte_out;
        rx_n++;
        if (mode == 2'd1)
          check(prev_n && !nib_clk, "R4", "strobe not at nib_clk fall", int'(nib_clk), 0);
        else if (mode == 2'd2)
          check(!prev_b && byte_clk, "R5", "strobe not at byte_clk rise", int'(byte_clk), 1);
        else
          check(1'b0, "R7", "strobe in non-capture mode", 1, 0);
      end
      prev_n = nib_clk;
      prev_b = byte_clk;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
  endtask

  task automatic feed_nibbles(input int n, ref logic [3:0] nb [32]);
    for (int i = 0; i < n; i++) begin
      @(posedge nib_clk);
      #1 data = {4'($urandom), nb[i]};
    end
    @(negedge nib_clk);
    tick();
    tick();
  endtask

  task automatic measure_hold(input logic byte_sel, input int h, input string req);
    int lo = 0;
    tick();
    while ((byte_sel ? byte_clk : nib_clk) == 1'b0 && lo < 1000) begin
      lo++;
      tick();
    end
    check(lo == 2 * h, req, "low hold after mode change", lo, 2 * h);
  endtask

  task automatic measure_width(input logic byte_sel, input int h);
    int hi = 0;
    int lo = 0;
    while ((byte_sel ? byte_clk : nib_clk) == 1'b0) tick();
    while ((byte_sel ? byte_clk : nib_clk) == 1'b1) begin hi++; tick(); end
    while ((byte_sel ? byte_clk : nib_clk) == 1'b0) begin lo++; tick(); end
    check(hi == h, "R2", "high width", hi, h);
    check(lo == h, "R2", "low width", lo, h);
  endtask

  initial begin
    logic [3:0] nb [32];
    logic [7:0] bb [32];
    int base;
    int h;
    void'($urandom(32'h1357));

    repeat (3) @(posedge clk);
    #2;
    check(!nib_clk && !byte_clk, "R2", "clocks low in reset", int'(nib_clk | byte_clk), 0);
    check(!vld, "R4", "no strobe in reset", int'(vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    // R2 / R8: clock widths and post-change hold (R1 mode codes 1 and 2)
    div = 8'd0;
    set_mode(2'd1);
    measure_hold(1'b0, 1, "R8");
    measure_width(1'b0, 1);
    set_mode(2'd0);
    repeat (3) tick();
    div = 8'd3;
    set_mode(2'd1);
    measure_hold(1'b0, 4, "R8");
    measure_width(1'b0, 4);
    set_mode(2'd2);
    measure_hold(1'b1, 4, "R8");
    measure_width(1'b1, 4);
    check(clk_hi_seen == 0, "R2", "wrong clock toggling", clk_hi_seen, 0);

    // R3 / R4: random nibble streams, random upper pins
    for (int r = 0; r < 3; r++) begin
      set_mode(2'd0);
      div = 8'($urandom_range(0, 4));
      repeat (2) tick();
      for (int i = 0; i < 16; i++) nb[i] = 4'($urandom);
      base = rx_n;
      set_mode(2'd1);
      feed_nibbles(16, nb);
      check(rx_n - base == 8, "R4", "nibble byte count", rx_n - base, 8);
      for (int k = 0; k < 8; k++)
        check(rx[8'(base + k)] == pack(nb[2*k], nb[2*k+1]), "R3",
              "packed byte", int'(rx[8'(base + k)]), int'(pack(nb[2*k], nb[2*k+1])));
    end

    // R5: random HDLC bytes
    for (int r = 0; r < 2; r++) begin
      set_mode(2'd0);
      div = 8'($urandom_range(0, 5));
      repeat (2) tick();
      for (int i = 0; i < 10; i++) bb[i] = 8'($urandom);
      bb[0] = (r == 0) ? 8'h00 : 8'hFF;
      base = rx_n;
      @(negedge clk);
      data = bb[0];
      mode = 2'd2;
      for (int i = 1; i < 10; i++) begin
        @(negedge byte_clk);
        #1 data = bb[i];
      end
      @(posedge byte_clk);
      tick();
      tick();
      check(rx_n - base == 10, "R5", "hdlc byte count", rx_n - base, 10);
      for (int k = 0; k < 10; k++)
        check(rx[8'(base + k)] == bb[k], "R5", "hdlc byte",
              int'(rx[8'(base + k)]), int'(bb[k]));
    end

    // R6 / R7: serial and ATM ignore the pins
    for (int m = 0; m < 2; m++) begin
      clk_hi_seen = 0;
      set_mode(m == 0 ? 2'd0 : 2'd3);
      base = rx_n;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        data = 8'($urandom);
      end
      tick();
      check(rx_n == base, m == 0 ? "R6" : "R7", "strobes while pins ignored", rx_n - base, 0);
      check(clk_hi_seen == 0, m == 0 ? "R6" : "R7", "pin clock active", clk_hi_seen, 0);
    end

    // R8: lone nibble dropped by a mode change
    div = 8'd1;
    for (int i = 0; i < 5; i++) nb[i] = 4'($urandom);
    base = rx_n;
    set_mode(2'd1);
    feed_nibbles(3, nb);
    set_mode(2'd0);
    repeat (3) tick();
    set_mode(2'd1);
    nb[0] = nb[3];
    nb[1] = nb[4];
    feed_nibbles(2, nb);
    check(rx_n - base == 2, "R8", "byte count around drop", rx_n - base, 2);
    check(rx[8'(base + 1)] == pack(nb[0], nb[1]), "R8", "fresh byte after drop",
          int'(rx[8'(base + 1)]), int'(pack(nb[0], nb[1])));

    // R8: mode change on the very edge of the second nibble capture
    set_mode(2'd0);
    div = 8'd2;
    h = 3;
    repeat (2) tick();
    nb[0] = 4'hA;
    base = rx_n;
    set_mode(2'd1);
    feed_nibbles(1, nb);
    @(posedge nib_clk);
    #1 data = 8'h05;
    repeat (h - 1) @(posedge clk);
    @(negedge clk);
    mode = 2'd0;
    repeat (6) tick();
    check(rx_n == base, "R8", "capture on change edge", rx_n - base, 0);
    nb[0] = 4'h3;
    nb[1] = 4'hC;
    set_mode(2'd1);
    feed_nibbles(2, nb);
    check(rx_n - base == 1, "R8", "one byte after edge change", rx_n - base, 1);
    check(rx[8'(base)] == 8'h3C, "R8", "fresh byte after edge change",
          int'(rx[8'(base)]), 8'h3C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule